// File: doc/BRIEF.md
# CPU error status register

This block keeps a record of why the processor last took an abort or an error trap. The execution and memory units each raise a one-cycle pulse when they detect a cause. Six causes are recorded: a halt attempted outside kernel mode, an odd address, non-existent memory, a bus timeout, a yellow stack trap and a red stack abort. Each pulse sets its own bit in a 16-bit register. The bit stays set until software writes the register. Any write clears every bit, and the written data plays no part.

A qualifier input, `stk_fatal`, marks a cycle in which a stack push failed during an abort. In that cycle only the original cause bit is recorded. The red and yellow stack bits stay untouched. If the failure came from memory management, no cause pulse arrives, so nothing is recorded at all. A red stack abort also stops the yellow bit from being set in the same cycle. The register is read through a plain read strobe. When the strobe is low, the read value is zero.

Top module: `cpu_fault_status`

## Requirements
- R1: Reset clears the whole register, so a read after reset returns 0.
- R2: Bit positions are halt 7, odd address 6, non-existent memory 5, bus timeout 4, yellow stack 3 and red stack 2. Bits 15:8 and 1:0 always read 0, and `rdata` is 0 whenever `bus_rd` is low.
- R3: A pulse on `ev_halt`, `ev_odd`, `ev_nxm` or `ev_timeout` sets its bit (7, 6, 5 or 4) from the next clock edge on. This holds whether or not `stk_fatal` is high.
- R4: A pulse on `ev_yellow` sets bit 3. A pulse on `ev_red` sets bit 2. When both arrive in the same cycle, bit 3 is not set by that cycle.
- R5: While `stk_fatal` is high, `ev_red` and `ev_yellow` set nothing. If `stk_fatal` is high with no cause pulse, the register does not change.
- R6: Bits accumulate. A set bit stays set until a write, and any new pulse adds to the bits already set.
- R7: A cycle with `bus_wr` high and no cause pulse leaves the register at 0. This holds for any `bus_wdata`, including zero, all ones, the complement of the current value and single-bit values.
- R8: When a write and cause pulses share a cycle, the register afterwards holds exactly the bits those pulses set.
- R9: Reading has no side effect: a read leaves every bit as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_halt | input | 1 | Halt attempted outside kernel mode |
| ev_odd | input | 1 | Odd address access |
| ev_nxm | input | 1 | Non-existent memory access |
| ev_timeout | input | 1 | Bus timeout in the I/O page |
| ev_yellow | input | 1 | Push into the yellow stack zone |
| ev_red | input | 1 | Push into the red stack zone |
| stk_fatal | input | 1 | The current cause hit a stack push during an abort |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data (ignored) |
| bus_rd | input | 1 | Register read strobe |
| rdata | output | 16 | Read value |

## Verification
The assertions take for granted that each cause pulse describes one cycle only. They also assume `stk_fatal` appears only together with a failed push, so a yellow, red or fatal pulse may coincide with any other input. They make no assumption about `bus_wdata`.

The random stimulus keeps each pulse rare and independent, and lets writes land at random. Collisions of a write with a pulse, of red with yellow, and of `stk_fatal` with each cause therefore all occur. Directed cases cover the exact write data patterns and a `stk_fatal` pulse with no cause.

// File: rtl/cpu_fault_status.sv
module cpu_fault_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_halt,
  input  logic              ev_odd,
  input  logic              ev_nxm,
  input  logic              ev_timeout,
  input  logic              ev_yellow,
  input  logic              ev_red,
  input  logic              stk_fatal,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] rdata
);
  localparam int B_HALT = 7;
  localparam int B_ODD  = 6;
  localparam int B_NXM  = 5;
  localparam int B_TMO  = 4;
  localparam int B_YEL  = 3;
  localparam int B_RED  = 2;

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] set_v;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    set_v         = '0;
    set_v[B_HALT] = ev_halt;
    set_v[B_ODD]  = ev_odd;
    set_v[B_NXM]  = ev_nxm;
    set_v[B_TMO]  = ev_timeout;
    set_v[B_YEL]  = ev_yellow & ~ev_red & ~stk_fatal;
    set_v[B_RED]  = ev_red & ~stk_fatal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (bus_wr ? '0 : status_q) | set_v;
  end

  assign rdata = bus_rd ? status_q : '0;
endmodule

// File: rtl/cpu_fault_status_chk.sv
module cpu_fault_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_halt,
  input logic        ev_odd,
  input logic        ev_nxm,
  input logic        ev_timeout,
  input logic        ev_yellow,
  input logic        ev_red,
  input logic        stk_fatal,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] rdata,
  input logic [15:0] status
);
  logic any_ev;
  assign any_ev = ev_halt | ev_odd | ev_nxm | ev_timeout | ev_yellow | ev_red;

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[15:8] == 8'h00) && (rdata[1:0] == 2'b00)) else $error("unused bits"); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> rdata == 16'h0) else $error("read idle"); // R2
  AST_HALT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> status[7]) else $error("halt bit"); // R3
  AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> status[4]) else $error("timeout bit"); // R3
  AST_RED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_red && !stk_fatal) |=> status[2]) else $error("red bit"); // R4
  AST_RED_MASKS_YELLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_red && bus_wr) |=> !status[3]) else $error("yellow with red"); // R4
  AST_FATAL_NO_STACK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_fatal && bus_wr) |=> status[3:2] == 2'b00) else $error("fatal stack"); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (status & $past(status)) == $past(status)) else $error("sticky"); // R6
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !any_ev) |=> status == 16'h0) else $error("write clear"); // R7
endmodule

bind cpu_fault_status cpu_fault_status_chk chk (
  .clk(clk), .rst_n(rst_n), .ev_halt(ev_halt), .ev_odd(ev_odd), .ev_nxm(ev_nxm),
  .ev_timeout(ev_timeout), .ev_yellow(ev_yellow), .ev_red(ev_red),
  .stk_fatal(stk_fatal), .bus_wr(bus_wr), .bus_rd(bus_rd), .rdata(rdata),
  .status(status_q)
);

// File: tb/tb_cpu_fault_status.sv
`timescale 1ns/1ps
module tb_cpu_fault_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_halt = 0, ev_odd = 0, ev_nxm = 0, ev_timeout = 0;
  logic        ev_yellow = 0, ev_red = 0, stk_fatal = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rdata;
  logic [15:0] exp_q = '0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  cpu_fault_status dut (
    .clk(clk), .rst_n(rst_n), .ev_halt(ev_halt), .ev_odd(ev_odd), .ev_nxm(ev_nxm),
    .ev_timeout(ev_timeout), .ev_yellow(ev_yellow), .ev_red(ev_red),
    .stk_fatal(stk_fatal), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .rdata(rdata)
  );

  // ev: [0] halt [1] odd [2] nxm [3] timeout [4] yellow [5] red [6] fatal
  function automatic logic [15:0] model(logic [15:0] cur, logic [6:0] ev, logic wr);
    logic [15:0] s = '0;
    s[7] = ev[0];
    s[6] = ev[1];
    s[5] = ev[2];
    s[4] = ev[3];
    s[3] = ev[4] && !ev[5] && !ev[6];
    s[2] = ev[5] && !ev[6];
    return (wr ? 16'h0 : cur) | s;
  endfunction

  task automatic cyc(logic [6:0] ev, logic wr, logic [15:0] wd);
    @(negedge clk);
    {stk_fatal, ev_red, ev_yellow, ev_timeout, ev_nxm, ev_odd, ev_halt} = ev;
    bus_wr = wr;
    bus_wdata = wd;
    @(posedge clk);
    #1;
    exp_q = model(exp_q, ev, wr);
    {stk_fatal, ev_red, ev_yellow, ev_timeout, ev_nxm, ev_odd, ev_halt} = '0;
    bus_wr = 0;
  endtask

  task automatic check(string req);
    n_chk++;
    if (rdata !== 16'h0) begin
      n_err++;
      $display("FAIL %s idle read: actual %h expected 0000", req, rdata);
    end
    bus_rd = 1;
    #1;
    n_chk++;
    if (rdata !== exp_q) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, rdata, exp_q);
    end
    bus_rd = 0;
    #1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    check("R1");
    cyc(7'b0000001, 0, 0); check("R3 halt");
    cyc(7'b0000010, 0, 0); check("R3 odd R6");
    cyc(7'b0000100, 0, 0); check("R3 nxm R6");
    cyc(7'b0001000, 0, 0); check("R3 timeout R6");
    cyc(7'b0000000, 0, 0); check("R9 read keeps bits");
    check("R9 second read");
    cyc(7'b0000000, 1, 16'h0000); check("R7 zero data");
    cyc(7'b0010000, 0, 0); check("R4 yellow");
    cyc(7'b0000000, 1, 16'hFFFF); check("R7 all ones");
    cyc(7'b0110000, 0, 0); check("R4 red masks yellow");
    cyc(7'b0000000, 1, ~16'h0004); check("R7 complement");
    cyc(7'b1000000, 0, 0); check("R5 fatal alone");
    cyc(7'b1110010, 0, 0); check("R5 fatal with odd");
    cyc(7'b0000000, 1, 16'h0040); check("R7 single bit");
    cyc(7'b1000100, 0, 0); check("R5 fatal with nxm");
    cyc(7'b1001000, 1, 16'h1234); check("R8 write with timeout");
    cyc(7'b0000001, 1, 16'h0000); check("R8 write with halt");
    cyc(7'b0000000, 1, 16'h0000); check("R2 R7");
    for (int i = 0; i < 400; i++) begin
      logic [6:0] ev;
      for (int b = 0; b < 7; b++) ev[b] = ($urandom % 8) == 0;
      cyc(ev, ($urandom % 6) == 0, 16'($urandom));
      check("R6 R8 random");
    end
    rst_n = 0;
    cyc(7'b0000001, 0, 0);
    exp_q = '0;
    rst_n = 1;
    check("R1 reset again");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule